// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block picks, every clock cycle, which hardware thread of a shared processing element gets the next instruction fetch. Each thread owns only a program counter; the selector holds those counters and presents the chosen thread's number and its counter to the fetch stage, in the same cycle as the choice.

Each thread has a ready flag. A thread also becomes ineligible while it has a memory access outstanding; a per-thread issue pulse marks the access and a per-thread completion pulse ends it. Two scheduling policies are available through a mode input. With the mode input low, the fetch rotates to another thread on every cycle. With the mode input high, one thread keeps fetching until a long-latency event pulse, or the loss of its own eligibility, moves fetch to another thread. A redirect port loads a new counter value into any thread.

Top module: `mt_fetch_sel`

## Requirements
- R1: With `block_mode` low, each fetch goes to the first eligible thread found by scanning upward (wrapping) from the thread that received the previous fetch plus one; that previous thread is picked again only when it is the sole eligible thread.
- R2: Changing thread costs no cycle: `fetch_valid` is high in every cycle in which at least one thread is eligible, and `fetch_tid`/`fetch_pc` describe that cycle's choice combinationally.
- R3: A thread i is eligible when `thr_ready[i]` is 1 and it has no access pending. A pulse on `mem_issue[i]` makes it pending from the next cycle; a pulse on `mem_done[i]` clears it from the next cycle; when both pulse in one cycle the thread stays pending.
- R4: With `block_mode` high and no switch requested, the thread that received the previous fetch keeps receiving fetches for as long as it stays eligible.
- R5: A `long_evt` pulse in a cycle requests a switch: in block mode, the next cycle that has a fetch picks by the R1 scan instead of holding; the request is consumed by that fetch.
- R6: In block mode, when the previously fetched thread is not eligible, the R1 scan picks the thread.
- R7: When no thread is eligible, `fetch_valid` is 0 and no counter, no rotation position and no hold thread changes (redirects excepted).
- R8: `fetch_pc` equals the selected thread's counter, and that counter advances by `INSTR_BYTES` (default 4) after each fetch it receives.
- R9: A redirect (`redir_valid` high) sets the counter of thread `redir_tid` to `redir_pc` from the next cycle, taking priority over the R8 advance of that thread.
- R10: After reset every counter equals `RESET_PC` (default 0), no thread is pending, no switch is requested, and the first fetch picks by scanning from thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | NTHREADS | Per-thread ready flags |
| mem_issue | input | NTHREADS | Per-thread pulse: memory access now outstanding |
| mem_done | input | NTHREADS | Per-thread pulse: memory access completed |
| long_evt | input | 1 | Long-latency event pulse, requests a thread switch |
| block_mode | input | 1 | 0: rotate every fetch, 1: hold thread until a switch |
| redir_valid | input | 1 | Load a new counter value |
| redir_tid | input | TID_W | Thread whose counter is loaded |
| redir_pc | input | PC_W | Value loaded |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_tid | output | TID_W | Selected thread |
| fetch_pc | output | PC_W | Counter of the selected thread |

## Verification
The bench chases the wrap of the rotation scan past the highest thread and the case where only the last-fetched thread is eligible; a scan off by one would skip or starve a thread, and a scan that excluded the previous thread would leave fetch idle. It drives issue and completion pulses in the same cycle, where a design giving completion priority would let a thread fetch during its own miss. It sends long-latency pulses both during fetch and during idle cycles, where a request lost while idle or kept after use would hold or rotate at the wrong cycle, and it redirects a thread in the very cycle it fetches, where a wrong priority would add the increment to the new counter.

// File: rtl/mt_fetch_sel.sv
module mt_fetch_sel #(
  parameter int NTHREADS    = 4,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHREADS-1:0] thr_ready,
  input  logic [NTHREADS-1:0] mem_issue,
  input  logic [NTHREADS-1:0] mem_done,
  input  logic                long_evt,
  input  logic                block_mode,
  input  logic                redir_valid,
  input  logic [TID_W-1:0]    redir_tid,
  input  logic [PC_W-1:0]     redir_pc,
  output logic                fetch_valid,
  output logic [TID_W-1:0]    fetch_tid,
  output logic [PC_W-1:0]     fetch_pc
);

  logic [PC_W-1:0]     pc_q [NTHREADS];
  logic [NTHREADS-1:0] pend_q;
  logic [TID_W-1:0]    last_q;
  logic                sw_q;
  logic [NTHREADS-1:0] elig;
  logic [TID_W-1:0]    rr_tid;
  logic                rr_hit;
  logic                hold;

  assign elig = thr_ready & ~pend_q;
  assign hold = block_mode && !sw_q && elig[last_q];

  always_comb begin
    rr_tid = last_q;
    rr_hit = 1'b0;
    for (int k = 1; k <= NTHREADS; k++) begin
      if (!rr_hit && elig[(int'(last_q) + k) % NTHREADS]) begin
        rr_hit = 1'b1;
        rr_tid = TID_W'((int'(last_q) + k) % NTHREADS);
      end
    end
  end

  assign fetch_valid = |elig;
  assign fetch_tid   = hold ? last_q : rr_tid;
  assign fetch_pc    = pc_q[fetch_tid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      last_q <= TID_W'(NTHREADS - 1);
      sw_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~mem_done) | mem_issue;
      sw_q   <= long_evt | (sw_q & ~fetch_valid);
      if (fetch_valid) last_q <= fetch_tid;
    end
  end

  for (genvar t = 0; t < NTHREADS; t++) begin : g_pc
    always_ff @(posedge clk) begin
      if (!rst_n)
        pc_q[t] <= RESET_PC;
      else if (redir_valid && redir_tid == TID_W'(t))
        pc_q[t] <= redir_pc;
      else if (fetch_valid && fetch_tid == TID_W'(t))
        pc_q[t] <= pc_q[t] + PC_W'(INSTR_BYTES);
    end
  end

endmodule

// File: rtl/mt_fetch_sel_chk.sv
module mt_fetch_sel_chk #(
  parameter int NTHREADS    = 4,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NTHREADS-1:0] thr_ready,
  input logic                block_mode,
  input logic                long_evt,
  input logic                redir_valid,
  input logic [TID_W-1:0]    redir_tid,
  input logic [PC_W-1:0]     redir_pc,
  input logic                fetch_valid,
  input logic [TID_W-1:0]    fetch_tid,
  input logic [PC_W-1:0]     fetch_pc,
  input logic [NTHREADS-1:0] pend_q,
  input logic [PC_W-1:0]     pc_q [NTHREADS]
);

  p_sel_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (thr_ready[fetch_tid] && !pend_q[fetch_tid]));

  p_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_mode && fetch_valid && $past(fetch_valid) && $past(rst_n) &&
     fetch_tid == $past(fetch_tid)) |-> ($countones(thr_ready & ~pend_q) == 1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !long_evt) |=>
      (!(block_mode && thr_ready[$past(fetch_tid)] && !pend_q[$past(fetch_tid)])
       || fetch_tid == $past(fetch_tid)));

  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !(redir_valid && redir_tid == fetch_tid)) |=>
      pc_q[$past(fetch_tid)] == $past(fetch_pc) + PC_W'(INSTR_BYTES));

  p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> pc_q[$past(redir_tid)] == $past(redir_pc));

endmodule

bind mt_fetch_sel mt_fetch_sel_chk #(
  .NTHREADS(NTHREADS), .PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .block_mode(block_mode),
  .long_evt(long_evt), .redir_valid(redir_valid), .redir_tid(redir_tid),
  .redir_pc(redir_pc), .fetch_valid(fetch_valid), .fetch_tid(fetch_tid),
  .fetch_pc(fetch_pc), .pend_q(pend_q), .pc_q(pc_q)
);

// File: tb/test_mt_fetch_sel.sv
module test_mt_fetch_sel;
  localparam int N = 4;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] thr_ready = '0, mem_issue = '0, mem_done = '0;
  logic long_evt = 1'b0, block_mode = 1'b0, redir_valid = 1'b0;
  logic [TW-1:0] redir_tid = '0;
  logic [31:0] redir_pc = '0;
  logic fetch_valid;
  logic [TW-1:0] fetch_tid;
  logic [31:0] fetch_pc;

  int n_tests = 0, n_fail = 0;

  logic [31:0] m_pc [N];
  bit [N-1:0] m_pend;
  int m_last;
  bit m_sw;

  always #2 clk = ~clk;

  mt_fetch_sel i_mt_fetch_sel (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .mem_issue(mem_issue),
    .mem_done(mem_done), .long_evt(long_evt), .block_mode(block_mode),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_pc[i] = 32'h0;
    m_pend = '0;
    m_last = N - 1;
    m_sw = 1'b0;
  endtask

  // one cycle: drive, compare against the model, then advance the model
  task automatic step(input logic [N-1:0] rdy, input logic [N-1:0] iss,
                      input logic [N-1:0] dne, input logic ev, input logic blk,
                      input logic rv, input int rt, input logic [31:0] rp,
                      input string tag);
    bit [N-1:0] el;
    bit valid;
    int pick;
    @(negedge clk);
    thr_ready = rdy; mem_issue = iss; mem_done = dne; long_evt = ev;
    block_mode = blk; redir_valid = rv; redir_tid = TW'(rt); redir_pc = rp;
    #1;
    el = rdy & ~m_pend;
    valid = (el != 0);
    pick = m_last;
    if (blk && !m_sw && el[m_last]) pick = m_last;
    else begin
      for (int k = 1; k <= N; k++) begin
        int c = (m_last + k) % N;
        if (el[c]) begin pick = c; break; end
      end
    end
    check(fetch_valid == valid, tag, "fetch_valid", fetch_valid, valid);
    if (valid) begin
      check(int'(fetch_tid) == pick, tag, "fetch_tid", fetch_tid, pick);
      check(fetch_pc == m_pc[pick], tag, "fetch_pc", fetch_pc, m_pc[pick]);
    end
    if (valid) begin
      m_pc[pick] = m_pc[pick] + 32'd4;
      m_last = pick;
    end
    if (rv) m_pc[rt] = rp;
    m_pend = (m_pend & ~dne) | iss;
    m_sw = ev | (m_sw & !valid);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: first pick after reset is thread 0 with the reset counter
    step('1, '0, '0, 0, 0, 0, 0, 0, "R10");
    // R1: full rotation with wrap, then sparse and sole-eligible patterns
    repeat (9) step('1, '0, '0, 0, 0, 0, 0, 0, "R1");
    repeat (6) step(4'b1010, '0, '0, 0, 0, 0, 0, 0, "R1");
    repeat (3) step(4'b0100, '0, '0, 0, 0, 0, 0, 0, "R1");
    // R3: pending hides a thread; issue and completion together keep it pending
    step('1, 4'b0010, '0, 0, 0, 0, 0, 0, "R3");
    repeat (5) step('1, '0, '0, 0, 0, 0, 0, 0, "R3");
    step('1, 4'b0001, 4'b0011, 0, 0, 0, 0, 0, "R3");
    repeat (5) step('1, '0, '0, 0, 0, 0, 0, 0, "R3");
    step('1, '0, 4'b0001, 0, 0, 0, 0, 0, "R3");
    repeat (4) step('1, '0, '0, 0, 0, 0, 0, 0, "R3");
    // R7: idle cycles, a switch request arriving while idle
    repeat (3) step('0, '0, '0, 0, 1, 0, 0, 0, "R7");
    step('0, '0, '0, 1, 1, 0, 0, 0, "R7");
    repeat (3) step('1, '0, '0, 0, 1, 0, 0, 0, "R5");
    // R4: hold thread in block mode
    repeat (6) step('1, '0, '0, 0, 1, 0, 0, 0, "R4");
    // R5: switch on long-latency pulse
    step('1, '0, '0, 1, 1, 0, 0, 0, "R5");
    repeat (4) step('1, '0, '0, 0, 1, 0, 0, 0, "R5");
    step('1, '0, '0, 1, 1, 0, 0, 0, "R5");
    step('1, '0, '0, 1, 1, 0, 0, 0, "R5");
    repeat (3) step('1, '0, '0, 0, 1, 0, 0, 0, "R5");
    // R6: held thread loses eligibility
    step('1, 4'b1111, '0, 0, 1, 0, 0, 0, "R6");
    step('1, '0, 4'b0100, 0, 1, 0, 0, 0, "R6");
    repeat (3) step('1, '0, 4'b1011, 0, 1, 0, 0, 0, "R6");
    repeat (3) step(4'b1001, '0, '0, 0, 1, 0, 0, 0, "R6");
    // R9: redirect, including the thread fetching in the same cycle
    step('1, '0, '0, 0, 0, 1, 1, 32'h0000_1000, "R9");
    step('1, '0, '0, 0, 0, 1, 3, 32'h0000_2000, "R9");
    step('1, '0, '0, 0, 0, 1, 2, 32'h0000_3000, "R9");
    repeat (8) step('1, '0, '0, 0, 0, 0, 0, 0, "R9");
    // R8: counter near wrap
    step('1, '0, '0, 0, 1, 1, 0, 32'hFFFF_FFF8, "R8");
    repeat (8) step('1, '0, '0, 0, 1, 0, 0, 0, "R8");
    // R2: mixed traffic
    for (int c = 0; c < 600; c++) begin
      logic [N-1:0] r = N'($urandom);
      logic [N-1:0] is = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) : '0;
      logic [N-1:0] dn = N'($urandom) & N'($urandom);
      logic ev = (($urandom % 5) == 0);
      logic bm = (c / 100) % 2 == 1;
      logic rv = (($urandom % 9) == 0);
      step(r, is, dn, ev, bm, rv, int'($urandom % N), $urandom, "R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule